// File: doc/BRIEF.md
# Unified Register File with Sticky Exception Flags

This block holds the architectural register state of a processor in one flat index space. Integer, floating-point and special registers all live there. Flat indices 0 to 31 hold the integer registers. Indices 32 to 47 form the low floating-point bank and 48 to 63 the high floating-point bank. Indices 64 to 95 hold the special registers.

One instruction retires per cycle. Each retiring instruction supplies a destination descriptor: a kind, a 5-bit register field and a double-precision flag. It also supplies a low result word, a high result word and a cause word. The block turns the descriptor into at most two flat destination indices and discards any write aimed at index 0. It routes the high result word to registers in the high floating-point bank and the low word to every other register.

On every retire, the IEEE exception-flag register ORs the cause bits into its five sticky flags. A direct write to that register by the same instruction overrides the accumulation. Four combinational read ports return the value at any flat index.

Top module: `unified_regfile`

## Requirements
- R1: After synchronous reset every register reads 0, and an index of 96 or above always reads 0.
- R2: With kind 2'b01 (integer), the register at flat index equal to the 5-bit field takes the low result word.
- R3: A write whose decoded flat index is 0 is discarded, so index 0 always reads 0.
- R4: With kind 2'b10 (floating point) and the double flag set, index 32+field[4:1] takes the low word and index 48+field[4:1] takes the high word.
- R5: With kind 2'b10 and the double flag clear, an even field writes only 32+field[4:1] with the low word. An odd field writes only 48+field[4:1] with the high word.
- R6: With kind 2'b11 (special), index 64+field takes the low word when field is at most SPR_LAST (default 9). Otherwise nothing is written.
- R7: On each retire, flag register bits [4:0] become their old value ORed with cause bits [11:7]. Bits [31:5] keep their value. The flag register sits at special number FLAG_SPR (default 7, flat index 71).
- R8: When a retiring instruction writes the flag register directly (kind 2'b11, field FLAG_SPR), the flag register takes the low word and the cause bits are not merged.
- R9: With retire_valid low no register changes, whatever the other inputs carry. This includes the flag register.
- R10: Kind 2'b00 writes no register but still merges its cause bits into the flags.
- R11: All four read ports return the current contents of the indexed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| retire_valid | input | 1 | An instruction retires this cycle |
| dst_kind | input | 2 | 00 none, 01 integer, 10 floating point, 11 special |
| dst_field | input | 5 | Register number field of the destination |
| dst_double | input | 1 | Floating-point result is double precision |
| res_lo | input | 32 | Result word 0 |
| res_hi | input | 32 | Result word 1 |
| res_cause | input | 32 | Cause word; bits [11:7] are the exception causes |
| rd_idx | input | 4x7 | Flat read index per port |
| rd_data | output | 4x32 | Read data per port |

## Verification
A wrong decode puts a result word into the wrong flat entry. A read of the intended index and of its neighbour in the other bank exposes this right after the retiring edge. A corrupted flag register shows on the next read of index 71: the lost bits stay lost, and stale or extra bits persist because the flags only ever accumulate. Writes leaking while retire_valid is low show at once as a changed value on a read port.

// File: rtl/unified_regfile.sv
module unified_regfile #(
  parameter int XLEN      = 32,
  parameter int NUM_INT   = 32,
  parameter int NUM_FPB   = 16,
  parameter int NUM_SPR   = 32,
  parameter int SPR_LAST  = 9,
  parameter int FLAG_SPR  = 7,
  parameter int FLAG_BITS = 5,
  parameter int CAUSE_LSB = 7,
  parameter int NRD       = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      retire_valid,
  input  logic [1:0]                dst_kind,
  input  logic [4:0]                dst_field,
  input  logic                      dst_double,
  input  logic [XLEN-1:0]           res_lo,
  input  logic [XLEN-1:0]           res_hi,
  input  logic [XLEN-1:0]           res_cause,
  input  logic [NRD-1:0][6:0]       rd_idx,
  output logic [NRD-1:0][XLEN-1:0]  rd_data
);
  localparam int FPL_BASE = NUM_INT;
  localparam int FPH_BASE = NUM_INT + NUM_FPB;
  localparam int SPR_BASE = NUM_INT + 2 * NUM_FPB;
  localparam int TOTAL    = SPR_BASE + NUM_SPR;
  localparam int FLAG_IDX = SPR_BASE + FLAG_SPR;

  logic [XLEN-1:0] rf [TOTAL];
  int idx0, idx1;

  always_comb begin
    idx0 = 0;
    idx1 = 0;
    case (dst_kind)
      2'b01: idx0 = int'(dst_field);
      2'b10: begin
        if (dst_double || !dst_field[0]) idx0 = FPL_BASE + int'(dst_field[4:1]);
        if (dst_double ||  dst_field[0]) idx1 = FPH_BASE + int'(dst_field[4:1]);
      end
      2'b11: if (int'(dst_field) <= SPR_LAST) idx0 = SPR_BASE + int'(dst_field);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TOTAL; i++) rf[i] <= '0;
    end else if (retire_valid) begin
      for (int i = 1; i < TOTAL; i++) begin
        if (idx0 == i || idx1 == i)
          rf[i] <= (i >= FPH_BASE && i < SPR_BASE) ? res_hi : res_lo;
        else if (i == FLAG_IDX)
          rf[i] <= {rf[i][XLEN-1:FLAG_BITS],
                    rf[i][FLAG_BITS-1:0] | res_cause[CAUSE_LSB +: FLAG_BITS]};
      end
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data[p] = (int'(rd_idx[p]) < TOTAL) ? rf[rd_idx[p]] : '0;
  end
endmodule

// File: rtl/unified_regfile_chk.sv
module unified_regfile_chk #(
  parameter int XLEN      = 32,
  parameter int FLAG_SPR  = 7,
  parameter int FLAG_BITS = 5,
  parameter int CAUSE_LSB = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            retire_valid,
  input logic [1:0]      dst_kind,
  input logic [4:0]      dst_field,
  input logic [XLEN-1:0] res_lo,
  input logic [XLEN-1:0] res_cause,
  input logic [XLEN-1:0] flag_q,
  input logic [XLEN-1:0] zero_q
);
  logic direct;
  assign direct = (dst_kind == 2'b11) && (int'(dst_field) == FLAG_SPR);

  p_zero_reg_r3: assert property (@(posedge clk) disable iff (rst)
    zero_q == '0);

  p_hold_flags_r9: assert property (@(posedge clk) disable iff (rst)
    !retire_valid |=> flag_q == $past(flag_q));

  p_sticky_low_r7: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !direct) |=>
      flag_q[FLAG_BITS-1:0] == ($past(flag_q[FLAG_BITS-1:0]) | $past(res_cause[CAUSE_LSB +: FLAG_BITS])));

  p_sticky_high_r7: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !direct) |=> flag_q[XLEN-1:FLAG_BITS] == $past(flag_q[XLEN-1:FLAG_BITS]));

  p_direct_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && direct) |=> flag_q == $past(res_lo));
endmodule

bind unified_regfile unified_regfile_chk #(
  .XLEN(XLEN), .FLAG_SPR(FLAG_SPR), .FLAG_BITS(FLAG_BITS), .CAUSE_LSB(CAUSE_LSB)
) chk_i (
  .clk(clk), .rst(rst), .retire_valid(retire_valid), .dst_kind(dst_kind),
  .dst_field(dst_field), .res_lo(res_lo), .res_cause(res_cause),
  .flag_q(rf[FLAG_IDX]), .zero_q(rf[0])
);

// File: tb/unified_regfile_tb.sv
module unified_regfile_tb_top;
  logic clk = 0, rst = 1, retire_valid = 0, dst_double = 0;
  logic [1:0] dst_kind = 0;
  logic [4:0] dst_field = 0;
  logic [31:0] res_lo = 0, res_hi = 0, res_cause = 0;
  logic [3:0][6:0] rd_idx = '0;
  logic [3:0][31:0] rd_data;
  int checks = 0, failures = 0, rr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  unified_regfile dut_i (.clk(clk), .rst(rst), .retire_valid(retire_valid),
    .dst_kind(dst_kind), .dst_field(dst_field), .dst_double(dst_double),
    .res_lo(res_lo), .res_hi(res_hi), .res_cause(res_cause),
    .rd_idx(rd_idx), .rd_data(rd_data));

  task automatic expect_reg(input string req, input int idx, input logic [31:0] exp);
    logic [31:0] v;
    int p = rr;
    rr = (rr + 1) % 4;
    rd_idx[p] = idx[6:0];
    #1;
    v = rd_data[p];
    checks++;
    if (v !== exp) begin
      failures++;
      $display("FAIL %s idx=%0d port=%0d actual=%h expected=%h", req, idx, p, v, exp);
    end
  endtask

  task automatic retire(input logic vld, input logic [1:0] k, input logic [4:0] f,
                        input logic dbl, input logic [31:0] lo, input logic [31:0] hi,
                        input logic [31:0] cause);
    @(negedge clk);
    retire_valid = vld; dst_kind = k; dst_field = f; dst_double = dbl;
    res_lo = lo; res_hi = hi; res_cause = cause;
    @(negedge clk);
    retire_valid = 0; res_cause = 0; dst_kind = 0;
  endtask

  task automatic do_reset;
    rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset;
    do_reset();
    expect_reg("R1", 0, 0);
    expect_reg("R1", 71, 0);
    expect_reg("R1", 95, 0);
    expect_reg("R1", 100, 0);
  endtask

  task automatic t_int;
    retire(1, 2'b01, 5'd5, 0, 32'hA5A5_0001, 32'h1111_1111, 0);
    expect_reg("R2", 5, 32'hA5A5_0001);
    expect_reg("R2", 4, 0);
    retire(1, 2'b01, 5'd0, 0, 32'hDEAD_BEEF, 0, 0);
    expect_reg("R3", 0, 0);
  endtask

  task automatic t_fp;
    retire(1, 2'b10, 5'd6, 1, 32'h0000_1234, 32'h5678_0000, 0);
    expect_reg("R4", 35, 32'h0000_1234);
    expect_reg("R4", 51, 32'h5678_0000);
    retire(1, 2'b10, 5'd10, 0, 32'h0000_AAAA, 32'h0000_BBBB, 0);
    expect_reg("R5", 37, 32'h0000_AAAA);
    expect_reg("R5", 53, 0);
    retire(1, 2'b10, 5'd11, 0, 32'h0000_CCCC, 32'h0000_DDDD, 0);
    expect_reg("R5", 53, 32'h0000_DDDD);
    expect_reg("R5", 37, 32'h0000_AAAA);
  endtask

  task automatic t_spr;
    retire(1, 2'b11, 5'd3, 0, 32'h3333_0003, 0, 0);
    expect_reg("R6", 67, 32'h3333_0003);
    retire(1, 2'b11, 5'd12, 0, 32'h7777_7777, 0, 0);
    expect_reg("R6", 76, 0);
    expect_reg("R6", 0, 0);
  endtask

  task automatic t_flags;
    retire(1, 2'b00, 5'd5, 0, 32'hFFFF_FFFF, 0, 32'h5 << 7);
    expect_reg("R10", 71, 32'h5);
    expect_reg("R10", 5, 32'hA5A5_0001);
    retire(1, 2'b01, 5'd9, 0, 32'h9, 0, 32'h10 << 7);
    expect_reg("R7", 71, 32'h15);
    retire(1, 2'b11, 5'd7, 0, 32'hABCD_EF00, 0, 32'h1F << 7);
    expect_reg("R8", 71, 32'hABCD_EF00);
    retire(1, 2'b00, 5'd0, 0, 0, 0, 32'h1 << 7);
    expect_reg("R7", 71, 32'hABCD_EF01);
  endtask

  task automatic t_hold;
    retire(0, 2'b01, 5'd5, 0, 32'h0BAD_0BAD, 0, 32'h1F << 7);
    expect_reg("R9", 5, 32'hA5A5_0001);
    expect_reg("R9", 71, 32'hABCD_EF01);
  endtask

  task automatic t_ports;
    rd_idx[0] = 7'd5; rd_idx[1] = 7'd35; rd_idx[2] = 7'd51; rd_idx[3] = 7'd67;
    #1;
    for (int p = 0; p < 4; p++) begin
      logic [31:0] e;
      e = (p == 0) ? 32'hA5A5_0001 : (p == 1) ? 32'h0000_1234 :
          (p == 2) ? 32'h5678_0000 : 32'h3333_0003;
      checks++;
      if (rd_data[p] !== e) begin
        failures++;
        $display("FAIL R11 port=%0d actual=%h expected=%h", p, rd_data[p], e);
      end
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    t_reset();
    t_int();
    t_fp();
    t_spr();
    t_flags();
    t_hold();
    t_ports();
    do_reset();
    expect_reg("R1", 5, 0);
    expect_reg("R1", 71, 0);
    done = 1;
    summary();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule